// File: doc/BRIEF.md
# Critical-Word-First Cache-Line Burst Sequencer

This block orders the data phases of one cache-line burst on an SDRAM data bus. It also produces the byte mask for each phase. A line holds four doublewords. The burst always begins with the doubleword the requester asked for, then wraps around the line, so the critical data arrives first. The bus runs in one of two widths. In 64-bit mode the line moves in four beats of one doubleword each. In 32-bit mode it moves in eight beats of one word each, and the word order starts at the first word of the requested doubleword.

A request carries the starting doubleword, a single-beat or full-line flag, the direction, eight byte enables and the bus-width flag. A one-cycle `start` pulse launches it. The block then presents one beat per cycle on `beat_valid`, `beat_idx` and `beat_mask`. It raises `done` for one cycle after the final beat.

A single-beat access still runs every phase of the line. The phases that do not carry the wanted data are masked with all mask lines high, so reads discard them and writes leave memory untouched. The surrounding controller owns command timing. This block only supplies the order and the masks.

Top module: `cwf_burst_seq`

## Requirements
- R1: After reset, and whenever no burst is running, `beat_valid` and `done` are 0 and `beat_idx` and `beat_mask` are all zeros.
- R2: A `start` seen in a cycle with `beat_valid` low is accepted. In the next cycle `beat_valid` is 1 and `beat_idx` equals the requested doubleword in 64-bit mode (`req_bus32`=0), or twice the requested doubleword in 32-bit mode (`req_bus32`=1).
- R3: In 64-bit mode a burst has exactly 4 consecutive beats, with `beat_idx` stepping by one modulo 4 (doubleword 2 gives 2,3,0,1).
- R4: In 32-bit mode a burst has exactly 8 consecutive beats, with `beat_idx` stepping by one modulo 8 (doubleword 2 gives 4,5,6,7,0,1,2,3).
- R5: A single-beat access (`req_single`=1) runs the same number of beats as a full-line access. It is never cut short.
- R6: `done` is 1 for exactly the one cycle that follows the last beat.
- R7: For a full-line access (`req_single`=0), `beat_mask` is all zeros on every beat, in both directions.
- R8: For a single-beat read, the targeted beats have `beat_mask` all zeros and every other beat has it all ones. The targeted beat is the first beat in 64-bit mode, or the first two beats in 32-bit mode.
- R9: For a single-beat write in 64-bit mode, the first beat's mask is the bitwise inverse of `req_be`, where bit n covers byte lane n. The other three beats are all ones.
- R10: For a single-beat write in 32-bit mode, bits 3:0 of the mask are the inverse of `req_be[3:0]` on the first beat and the inverse of `req_be[7:4]` on the second beat, with bits 7:4 zero on both. The remaining six beats are all ones.
- R11: A `start` that arrives while beats are being presented is ignored. The running burst keeps its order, masks and length.
- R12: A `start` in the `done` cycle is accepted, and the first beat of the new burst appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a burst with the request fields below |
| req_dword | input | 2 | Requested doubleword within the line |
| req_single | input | 1 | 1 = single-beat access, 0 = full line |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 8 | Byte enables for a single-beat write |
| req_bus32 | input | 1 | 1 = 32-bit data bus, 0 = 64-bit |
| beat_valid | output | 1 | A data phase is presented this cycle |
| beat_idx | output | 3 | Doubleword (64-bit) or word (32-bit) index of this beat |
| beat_mask | output | 8 | Data mask per byte lane, 1 = lane masked |
| done | output | 1 | One-cycle pulse after the last beat |

## Verification
Two functions can fall in the same cycle: the end-of-burst `done` pulse and the acceptance of the next request. The bench provokes this by raising `start` with new fields in the `done` cycle of a running burst. It then expects the next cycle to show the new burst's first index and mask, with no idle gap and no leftover beat from the old burst. A `start` placed in the middle of a burst is judged the opposite way: the remaining beats must follow the original request, and the total length must stay the same.

// File: rtl/cwf_burst_pkg.sv
package cwf_burst_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/cwf_beat_order.sv
module cwf_beat_order #(
    parameter int LINE_DW = 4
) (
    input  logic [$clog2(LINE_DW)-1:0] dword,
    input  logic [$clog2(LINE_DW):0]   cnt,
    input  logic                       bus32,
    output logic [$clog2(LINE_DW):0]   idx
);
    localparam int DW_W = $clog2(LINE_DW);
    localparam int WD_W = DW_W + 1;

    initial begin
        a_r3_pow2_line: assert ((1 << DW_W) == LINE_DW)
            else $error("line length must be a power of two");
    end

    logic [WD_W-1:0] word_base;
    logic [WD_W-1:0] idx_narrow;
    logic [WD_W-1:0] idx_wide;

    always_comb begin
        word_base  = {dword, 1'b0};
        idx_wide   = word_base + cnt;
        idx_narrow = {1'b0, DW_W'(dword + cnt[DW_W-1:0])};
        idx        = bus32 ? idx_wide : idx_narrow;
    end

endmodule

// File: rtl/cwf_beat_mask.sv
module cwf_beat_mask #(
    parameter int LANES  = 8,
    parameter int CNT_W  = 3
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             single,
    input  logic             write,
    input  logic             bus32,
    input  logic [LANES-1:0] be,
    output logic [LANES-1:0] mask
);
    localparam int HALF = LANES / 2;

    logic            targeted;
    logic [HALF-1:0] half_be;
    logic [LANES-1:0] write_mask;

    always_comb begin
        if (bus32) targeted = (cnt < CNT_W'(2));
        else       targeted = (cnt == '0);
        half_be = cnt[0] ? be[LANES-1:HALF] : be[HALF-1:0];
    end

    generate
        if (HALF > 0) begin : g_wide
            always_comb begin
                if (bus32) write_mask = {{(LANES-HALF){1'b0}}, ~half_be};
                else       write_mask = ~be;
            end
        end
    endgenerate

    always_comb begin
        if (!single)        mask = '0;
        else if (!targeted) mask = '1;
        else if (!write)    mask = '0;
        else                mask = write_mask;
    end

endmodule

// File: rtl/cwf_burst_seq.sv
module cwf_burst_seq
    import cwf_burst_pkg::*;
#(
    parameter int LINE_DW = 4,
    parameter int LANES   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [$clog2(LINE_DW)-1:0] req_dword,
    input  logic                       req_single,
    input  logic                       req_write,
    input  logic [LANES-1:0]           req_be,
    input  logic                       req_bus32,
    output logic                       beat_valid,
    output logic [$clog2(LINE_DW):0]   beat_idx,
    output logic [LANES-1:0]           beat_mask,
    output logic                       done
);
    localparam int DW_W  = $clog2(LINE_DW);
    localparam int WD_W  = DW_W + 1;
    localparam int CNT_W = WD_W;
    localparam int WORDS = 2 * LINE_DW;

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [DW_W-1:0]  dw;
        logic             single;
        logic             write;
        logic             bus32;
        logic [LANES-1:0] be;
    } seq_t;

    seq_t seq_d, seq_q;
    logic last_beat;
    logic [WD_W-1:0]  idx_raw;
    logic [LANES-1:0] mask_raw;

    always_comb begin
        last_beat = seq_q.bus32 ? (seq_q.cnt == CNT_W'(WORDS - 1))
                                : (seq_q.cnt == CNT_W'(LINE_DW - 1));
        seq_d = seq_q;
        case (seq_q.st)
            SEQ_RUN: begin
                if (last_beat) seq_d.st  = SEQ_FIN;
                else           seq_d.cnt = seq_q.cnt + 1'b1;
            end
            default: begin
                seq_d.st = SEQ_IDLE;
                if (start) begin
                    seq_d.st     = SEQ_RUN;
                    seq_d.cnt    = '0;
                    seq_d.dw     = req_dword;
                    seq_d.single = req_single;
                    seq_d.write  = req_write;
                    seq_d.bus32  = req_bus32;
                    seq_d.be     = req_be;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: SEQ_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    cwf_beat_order #(.LINE_DW(LINE_DW)) u_order (
        .dword (seq_q.dw),
        .cnt   (seq_q.cnt),
        .bus32 (seq_q.bus32),
        .idx   (idx_raw)
    );

    cwf_beat_mask #(.LANES(LANES), .CNT_W(CNT_W)) u_mask (
        .cnt    (seq_q.cnt),
        .single (seq_q.single),
        .write  (seq_q.write),
        .bus32  (seq_q.bus32),
        .be     (seq_q.be),
        .mask   (mask_raw)
    );

    always_comb begin
        beat_valid = (seq_q.st == SEQ_RUN);
        done       = (seq_q.st == SEQ_FIN);
        beat_idx   = beat_valid ? idx_raw  : '0;
        beat_mask  = beat_valid ? mask_raw : '0;
    end

    // R2: accepted request shows its first index one cycle later
    a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !beat_valid) |=> (beat_valid &&
            beat_idx == ($past(req_bus32) ? {$past(req_dword), 1'b0}
                                          : {1'b0, $past(req_dword)})));

    // R3: 64-bit beats step by one modulo the line
    a_r3_step_dw: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && $past(beat_valid) && !seq_q.bus32) |->
            beat_idx[DW_W-1:0] == DW_W'($past(beat_idx[DW_W-1:0]) + 1'b1));

    // R4: 32-bit beats step by one modulo the word count
    a_r4_step_word: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && $past(beat_valid) && seq_q.bus32) |->
            beat_idx == WD_W'($past(beat_idx) + 1'b1));

    // R5: no gap inside a burst
    a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !last_beat) |=> beat_valid);

    // R6: done follows a beat and lasts one cycle
    a_r6_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(beat_valid));
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: full-line beats carry no mask
    a_r7_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !seq_q.single) |-> beat_mask == '0);

    // R8: beats past the targeted ones are fully masked
    a_r8_untargeted: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && seq_q.single && seq_q.cnt >= CNT_W'(2)) |-> beat_mask == '1);

    // R11: a start during a burst leaves the captured request alone
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && start && !last_beat) |=>
            (beat_valid && seq_q.dw == $past(seq_q.dw) && seq_q.bus32 == $past(seq_q.bus32)));

endmodule

// File: tb/cwf_burst_seq_bench.sv
module cwf_burst_seq_bench;

    typedef struct packed {
        logic [1:0] dw;
        logic       single;
        logic       write;
        logic       bus32;
        logic [7:0] be;
        logic [2:0] first_idx;
        logic [3:0] nbeats;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TABLE [NV] = '{
        '{2'd2, 1'b0, 1'b0, 1'b0, 8'h00, 3'd2, 4'd4},  // R3 R7 full read 64
        '{2'd0, 1'b0, 1'b1, 1'b0, 8'hFF, 3'd0, 4'd4},  // R7 full write 64
        '{2'd2, 1'b0, 1'b0, 1'b1, 8'h00, 3'd4, 4'd8},  // R4 full read 32
        '{2'd3, 1'b0, 1'b1, 1'b1, 8'h5A, 3'd6, 4'd8},  // R4 R7 full write 32
        '{2'd1, 1'b1, 1'b0, 1'b0, 8'h0F, 3'd1, 4'd4},  // R5 R8 single read 64
        '{2'd3, 1'b1, 1'b0, 1'b1, 8'h33, 3'd6, 4'd8},  // R5 R8 single read 32
        '{2'd1, 1'b1, 1'b1, 1'b0, 8'hA5, 3'd1, 4'd4},  // R9 single write 64
        '{2'd0, 1'b1, 1'b1, 1'b0, 8'h01, 3'd0, 4'd4},  // R9 one lane
        '{2'd1, 1'b1, 1'b1, 1'b1, 8'hC3, 3'd2, 4'd8},  // R10 single write 32
        '{2'd2, 1'b1, 1'b1, 1'b1, 8'h00, 3'd4, 4'd8}   // R10 no lanes enabled
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] req_dword = '0;
    logic       req_single = 1'b0;
    logic       req_write = 1'b0;
    logic [7:0] req_be = '0;
    logic       req_bus32 = 1'b0;
    logic       beat_valid;
    logic [2:0] beat_idx;
    logic [7:0] beat_mask;
    logic       done;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    cwf_burst_seq u_cwf_burst_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .req_dword  (req_dword),
        .req_single (req_single),
        .req_write  (req_write),
        .req_be     (req_be),
        .req_bus32  (req_bus32),
        .beat_valid (beat_valid),
        .beat_idx   (beat_idx),
        .beat_mask  (beat_mask),
        .done       (done)
    );

    function automatic logic [2:0] exp_idx(vec_t v, int k);
        if (v.bus32) return 3'((2 * v.dw + k) % 8);
        return 3'((v.dw + k) % 4);
    endfunction

    function automatic logic [7:0] exp_mask(vec_t v, int k);
        logic tgt;
        if (!v.single) return 8'h00;
        tgt = v.bus32 ? (k < 2) : (k == 0);
        if (!tgt) return 8'hFF;
        if (!v.write) return 8'h00;
        if (!v.bus32) return ~v.be;
        return {4'h0, ~((k == 1) ? v.be[7:4] : v.be[3:0])};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive_req(vec_t v);
        start      = 1'b1;
        req_dword  = v.dw;
        req_single = v.single;
        req_write  = v.write;
        req_be     = v.be;
        req_bus32  = v.bus32;
    endtask

    // called at a falling edge where start was just driven; samples each beat
    task automatic check_beats(vec_t v, int inject);
        int n;
        n = v.bus32 ? 8 : 4;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k == 0 || k == inject + 1) start = 1'b0;
            check("R5 beat_valid", {31'd0, beat_valid}, 32'd1);
            check(v.bus32 ? "R4 order" : "R3 order", {29'd0, beat_idx}, {29'd0, exp_idx(v, k)});
            check(!v.single ? "R7 mask" : (!v.write ? "R8 mask" : (v.bus32 ? "R10 mask" : "R9 mask")),
                  {24'd0, beat_mask}, {24'd0, exp_mask(v, k)});
            if (k == 0) begin
                check("R2 first index", {29'd0, beat_idx}, {29'd0, v.first_idx});
                check("R5 length", {28'd0, 4'(n)}, {28'd0, v.nbeats});
            end
            if (k == inject) begin
                start      = 1'b1;
                req_dword  = ~v.dw;
                req_single = ~v.single;
                req_write  = ~v.write;
                req_bus32  = ~v.bus32;
                req_be     = ~v.be;
            end
            if (k < n - 1) check("R6 no early done", {31'd0, done}, 32'd0);
        end
    endtask

    task automatic finish_burst;
        @(negedge clk);
        check("R6 done after last", {31'd0, done}, 32'd1);
        check("R5 no extra beat", {31'd0, beat_valid}, 32'd0);
        @(negedge clk);
        check("R6 done one cycle", {31'd0, done}, 32'd0);
        check("R1 idle outputs", {20'd0, beat_valid, beat_idx, beat_mask},
              32'd0);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        vec_t a;
        vec_t b;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset valid", {31'd0, beat_valid}, 32'd0);
        check("R1 reset done", {31'd0, done}, 32'd0);
        check("R1 reset idx/mask", {21'd0, beat_idx, beat_mask}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {30'd0, beat_valid, done}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            drive_req(TABLE[i]);
            check_beats(TABLE[i], -1);
            finish_burst();
        end

        // R11: start mid-burst is ignored
        a = TABLE[5];
        drive_req(a);
        check_beats(a, 2);
        finish_burst();
        a = TABLE[6];
        drive_req(a);
        check_beats(a, 0);
        finish_burst();

        // R12: start in the done cycle chains bursts
        a = TABLE[0];
        b = TABLE[8];
        drive_req(a);
        check_beats(a, -1);
        @(negedge clk);
        check("R12 done cycle", {31'd0, done}, 32'd1);
        drive_req(b);
        check_beats(b, -1);
        @(negedge clk);
        check("R12 done cycle again", {31'd0, done}, 32'd1);
        drive_req(a);
        check_beats(a, -1);
        finish_burst();

        // R1: reset in the middle of a burst returns to idle
        drive_req(TABLE[3]);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-burst", {19'd0, beat_valid, done, beat_idx, beat_mask}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 stays idle", {30'd0, beat_valid, done}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule